// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block is a full-duplex asynchronous serial engine. Its transmit half takes one byte per handshake and sends it as a frame on a serial output. Its receive half watches a serial input, rebuilds each character and presents it for one cycle with its own error flags. The frame shape is chosen at run time: a 16-bit divisor sets the bit time, a 2-bit code picks the number of data bits, parity can be switched on with either sense, and one or two stop bits can be sent.

The engine holds no registers for software, no buffering and no interrupt logic. A surrounding controller drives the configuration inputs directly and uses the separate transmit and receive enables. A synchronous clear input returns both halves to idle while the configuration is left as it is. The idle line level is high. The start bit is low. Data bits go least significant bit first, and only the bits in use are sent.

Top module: `uart_frame_engine`

## Requirements
- R1: The transmit side accepts a byte in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only while the transmitter is idle and `tx_en` is set. The line idles high, and the frame opens with a low start bit in the cycle after acceptance.
- R2: Every bit on the line, in both directions, lasts `baud_div + 1` clock cycles.
- R3: `len_code` selects the data bit count: 0 gives 8, 1 gives 5, 2 gives 6 and 3 gives 7. Data bits are sent least significant bit first, and only the selected bits are sent.
- R4: When `par_en` is 1, one parity bit follows the data bits. `par_odd` = 1 makes the count of ones over the data and parity bits odd, and `par_odd` = 0 makes it even.
- R5: The data (or the parity bit, when enabled) is followed by one high stop bit, or by two when `two_stop` is 1. `tx_ready` returns exactly (1 + data bits + parity + stop bits) × (`baud_div` + 1) cycles after acceptance.
- R6: When `out_en` is 0, `txd` stays high for the whole frame.
- R7: The receiver passes `rxd` through two synchronising flops. It confirms the start bit half a bit time after the falling edge and samples each later bit at its centre. It then pulses `rx_valid` for one cycle, with the data right-aligned in `rx_data` and the unused high bits zero.
- R8: `rx_par_err` is set when parity is enabled and the received parity bit disagrees with the selected sense, unless the character is a break.
- R9: `rx_brk` is set when all data bits, the parity bit (if enabled) and the first stop bit are sampled low. `rx_frm_err` is set when the first stop bit is low and the character is not a break. The two flags are never set together.
- R10: A one-cycle `sw_clear` returns `txd` high and `tx_ready` to its idle value in the next cycle and aborts any frame being received. A frame sent afterwards uses the configuration that was in place before the clear.
- R11: With `tx_en` low, `tx_ready` stays low. With `rx_en` low, no new received frame is started and `rx_valid` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_clear | input | 1 | Synchronous clear of both halves, configuration kept |
| baud_div | input | 16 | Bit time minus one, in clock cycles |
| len_code | input | 2 | Data length code |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| two_stop | input | 1 | 1 = two stop bits on transmit |
| out_en | input | 1 | Serial output drive enable |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input, asynchronous |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| rx_data | output | 8 | Received character, right-aligned |
| rx_par_err | output | 1 | Parity error for this character |
| rx_frm_err | output | 1 | Framing error for this character |
| rx_brk | output | 1 | Break detected for this character |

## Verification
After the accepting clock edge, transmit bit i is due on `txd` from edge i·(D+1) up to edge (i+1)·(D+1), where D is `baud_div`. The bench counts edges from acceptance and samples each bit at the falling clock edge nearest its centre. It checks `tx_ready` one edge before and exactly at N·(D+1), where N is the frame's bit count. Because of the two-flop synchroniser and the half-bit start check, the receive strobe falls near the centre of the first stop bit, a few cycles later. A monitor therefore records every `rx_valid` pulse, and the result is checked after the whole frame plus two idle bit times. The clear is sampled one cycle after it is applied.

// File: rtl/ufe_pkg.sv
package ufe_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP1,
        PH_STOP2,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } frame_fmt_t;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_err;
        logic              frm_err;
        logic              brk;
    } rx_char_t;

    // Number of data bits for a length code (code 0 is the full width).
    function automatic logic [3:0] bits_of(input logic [1:0] code);
        case (code)
            2'd1:    return 4'd5;
            2'd2:    return 4'd6;
            2'd3:    return 4'd7;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [CHAR_W-1:0] mask_of(input logic [1:0] code);
        case (code)
            2'd1:    return 8'h1F;
            2'd2:    return 8'h3F;
            2'd3:    return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    // Parity bit value that gives the requested sense over the used bits.
    function automatic logic parity_of(input logic [CHAR_W-1:0] d,
                                       input logic [1:0] code,
                                       input logic odd);
        return (^(d & mask_of(code))) ^ odd;
    endfunction

    // Receive bits enter at the top; move them down to bit 0.
    function automatic logic [CHAR_W-1:0] align_rx(input logic [CHAR_W-1:0] sr,
                                                   input logic [1:0] code);
        case (code)
            2'd1:    return sr >> 3;
            2'd2:    return sr >> 2;
            2'd3:    return sr >> 1;
            default: return sr;
        endcase
    endfunction

endpackage

// File: rtl/ufe_bit_timer.sv
module ufe_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             hit
);
    logic [DIV_W-1:0] cnt;

    assign hit = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (clr || !run || hit)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ufe_tx.sv
module ufe_tx
    import ufe_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              clr,
    input  logic [DIV_W-1:0]  div,
    input  frame_fmt_t        fmt,
    input  logic              out_en,
    input  logic              tx_en,
    input  logic              tx_valid,
    input  logic [CHAR_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              txd
);
    phase_e            phase;
    frame_fmt_t        fmt_q;
    logic [CHAR_W-1:0] shreg;
    logic [3:0]        left;
    logic              par_q;
    logic              hit;
    logic              line;
    logic              take;

    ufe_bit_timer #(.DIV_W(DIV_W)) u_tmr (
        .clk  (clk),
        .clr  (clr),
        .run  (phase != PH_IDLE),
        .limit(div),
        .hit  (hit)
    );

    assign tx_ready = tx_en && (phase == PH_IDLE);
    assign take     = tx_valid && tx_ready;

    always_ff @(posedge clk) begin
        if (clr) begin
            phase <= PH_IDLE;
            fmt_q <= '0;
            shreg <= '0;
            left  <= '0;
            par_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (take) begin
                    phase <= PH_START;
                    fmt_q <= fmt;
                    shreg <= tx_data;
                    par_q <= parity_of(tx_data, fmt.len_code, fmt.par_odd);
                    left  <= bits_of(fmt.len_code) - 4'd1;
                end
                PH_START: if (hit) phase <= PH_DATA;
                PH_DATA: if (hit) begin
                    shreg <= shreg >> 1;
                    if (left == 4'd0)
                        phase <= fmt_q.par_en ? PH_PAR : PH_STOP1;
                    else
                        left <= left - 4'd1;
                end
                PH_PAR:   if (hit) phase <= PH_STOP1;
                PH_STOP1: if (hit) phase <= fmt_q.two_stop ? PH_STOP2 : PH_IDLE;
                PH_STOP2: if (hit) phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        case (phase)
            PH_START: line = 1'b0;
            PH_DATA:  line = shreg[0];
            PH_PAR:   line = par_q;
            default:  line = 1'b1;
        endcase
    end

    assign txd = out_en ? line : 1'b1;
endmodule

// File: rtl/ufe_rx.sv
module ufe_rx
    import ufe_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [DIV_W-1:0]  div,
    input  frame_fmt_t        fmt,
    input  logic              rx_en,
    input  logic              rxd,
    output logic              rx_valid,
    output rx_char_t          rx_char
);
    logic [1:0]        sync;
    logic              rxs;
    phase_e            phase;
    frame_fmt_t        fmt_q;
    logic [CHAR_W-1:0] shreg;
    logic [3:0]        left;
    logic              par_bit;
    logic              hit;
    logic [DIV_W-1:0]  limit;
    logic [CHAR_W-1:0] word;
    logic              all_low;
    rx_char_t          cur;

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rxd};
    end
    assign rxs = sync[1];

    // The start bit is checked half a bit in; later bits a full bit apart.
    assign limit = (phase == PH_START) ? (div >> 1) : div;

    ufe_bit_timer #(.DIV_W(DIV_W)) u_tmr (
        .clk  (clk),
        .clr  (clr),
        .run  (phase != PH_IDLE && phase != PH_HOLD),
        .limit(limit),
        .hit  (hit)
    );

    always_comb begin
        word        = align_rx(shreg, fmt_q.len_code);
        all_low     = (word == '0) && (!fmt_q.par_en || !par_bit) && !rxs;
        cur.data    = word;
        cur.brk     = all_low;
        cur.frm_err = !rxs && !all_low;
        cur.par_err = fmt_q.par_en && !all_low &&
                      (par_bit != parity_of(word, fmt_q.len_code, fmt_q.par_odd));
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            phase    <= PH_IDLE;
            rx_valid <= 1'b0;
            rx_char  <= '0;
            fmt_q    <= '0;
            shreg    <= '0;
            left     <= '0;
            par_bit  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            case (phase)
                PH_IDLE: if (rx_en && !rxs) begin
                    phase <= PH_START;
                    fmt_q <= fmt;
                    shreg <= '0;
                    left  <= bits_of(fmt.len_code) - 4'd1;
                end
                PH_START: if (hit) phase <= rxs ? PH_IDLE : PH_DATA;
                PH_DATA: if (hit) begin
                    shreg <= {rxs, shreg[CHAR_W-1:1]};
                    if (left == 4'd0)
                        phase <= fmt_q.par_en ? PH_PAR : PH_STOP1;
                    else
                        left <= left - 4'd1;
                end
                PH_PAR: if (hit) begin
                    par_bit <= rxs;
                    phase   <= PH_STOP1;
                end
                PH_STOP1: if (hit) begin
                    rx_valid <= 1'b1;
                    rx_char  <= cur;
                    phase    <= rxs ? PH_IDLE : PH_HOLD;
                end
                PH_HOLD: if (rxs) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
    import ufe_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_clear,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [1:0]        len_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              out_en,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              tx_valid,
    input  logic [CHAR_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    output logic              rx_valid,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_par_err,
    output logic              rx_frm_err,
    output logic              rx_brk
);
    frame_fmt_t fmt;
    rx_char_t   rch;
    logic       clr_all;

    assign fmt     = '{len_code: len_code, par_en: par_en, par_odd: par_odd,
                       two_stop: two_stop};
    assign clr_all = rst || sw_clear;

    ufe_tx #(.DIV_W(DIV_W)) u_tx (
        .clk     (clk),
        .clr     (clr_all),
        .div     (baud_div),
        .fmt     (fmt),
        .out_en  (out_en),
        .tx_en   (tx_en),
        .tx_valid(tx_valid),
        .tx_data (tx_data),
        .tx_ready(tx_ready),
        .txd     (txd)
    );

    ufe_rx #(.DIV_W(DIV_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_all),
        .div     (baud_div),
        .fmt     (fmt),
        .rx_en   (rx_en),
        .rxd     (rxd),
        .rx_valid(rx_valid),
        .rx_char (rch)
    );

    assign rx_data    = rch.data;
    assign rx_par_err = rch.par_err;
    assign rx_frm_err = rch.frm_err;
    assign rx_brk     = rch.brk;
endmodule

// File: rtl/ufe_checker.sv
module ufe_checker (
    input logic clk,
    input logic rst,
    input logic sw_clear,
    input logic out_en,
    input logic tx_valid,
    input logic tx_ready,
    input logic txd,
    input logic rx_valid,
    input logic rx_frm_err,
    input logic rx_brk
);
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !sw_clear) |=> (!txd || !out_en)); // R1

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !sw_clear) |=> !tx_ready); // R1

    AST_RX_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R7

    AST_BRK_EXCLUDES_FRM: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !(rx_brk && rx_frm_err)); // R9

    AST_CLEAR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        sw_clear |=> (txd && !rx_valid)); // R10
endmodule

bind uart_frame_engine ufe_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .sw_clear  (sw_clear),
    .out_en    (out_en),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .txd       (txd),
    .rx_valid  (rx_valid),
    .rx_frm_err(rx_frm_err),
    .rx_brk    (rx_brk)
);

// File: tb/sim_uart_frame_engine.sv
`timescale 1ns/1ps
module sim_uart_frame_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_clear = 1'b0;
    logic [15:0] baud_div = 16'd3;
    logic [1:0]  len_code = 2'd0;
    logic        par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic        out_en = 1'b1, tx_en = 1'b1, rx_en = 1'b1;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_ready, txd;
    logic        rxd = 1'b1;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_par_err, rx_frm_err, rx_brk;

    always #2.5 clk = ~clk;

    uart_frame_engine u0 (
        .clk(clk), .rst(rst), .sw_clear(sw_clear), .baud_div(baud_div),
        .len_code(len_code), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .out_en(out_en), .tx_en(tx_en), .rx_en(rx_en),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .txd(txd), .rxd(rxd), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk)
    );

    int checks = 0;
    int failures = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Receive monitor
    int         got_cnt = 0;
    logic [7:0] got_data;
    logic       got_pe, got_fe, got_bk;
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            got_cnt++;
            got_data = rx_data;
            got_pe   = rx_par_err;
            got_fe   = rx_frm_err;
            got_bk   = rx_brk;
        end
    end

    function automatic int nbits(input logic [1:0] c);
        case (c)
            2'd1: return 5;
            2'd2: return 6;
            2'd3: return 7;
            default: return 8;
        endcase
    endfunction

    function automatic logic [7:0] mask(input logic [1:0] c);
        return 8'((1 << nbits(c)) - 1);
    endfunction

    function automatic logic par_bit(input logic [7:0] d, input logic [1:0] c, input logic odd);
        logic p = odd;
        for (int i = 0; i < nbits(c); i++) p = p ^ d[i];
        return p;
    endfunction

    // edge counter for transmit sampling
    int el;
    bit at_neg;
    task automatic step_to(input int t);
        while (el < t) begin
            @(posedge clk);
            el++;
            at_neg = 0;
        end
        if (!at_neg) begin
            @(negedge clk);
            at_neg = 1;
        end
    endtask

    task automatic tx_frame(input logic [7:0] d);
        int    p = int'(baud_div) + 1;
        int    h = p / 2;
        int    n = nbits(len_code);
        int    nf;
        logic  bits [0:11];
        string tg [0:11];
        int    w = 0;
        bits[0] = 1'b0; tg[0] = "R1 start";
        for (int i = 0; i < n; i++) begin bits[1+i] = d[i]; tg[1+i] = "R3 data"; end
        nf = 1 + n;
        if (par_en) begin bits[nf] = par_bit(d, len_code, par_odd); tg[nf] = "R4 parity"; nf++; end
        bits[nf] = 1'b1; tg[nf] = "R5 stop"; nf++;
        if (two_stop) begin bits[nf] = 1'b1; tg[nf] = "R5 stop2"; nf++; end
        if (!out_en)
            for (int i = 0; i < nf; i++) begin bits[i] = 1'b1; tg[i] = "R6 out_en"; end
        @(negedge clk);
        while (!tx_ready && w < 2000) begin @(negedge clk); w++; end
        tx_data  = d;
        tx_valid = 1'b1;
        @(posedge clk);
        #1 tx_valid = 1'b0;
        el = 0;
        at_neg = 0;
        for (int i = 0; i < nf; i++) begin
            step_to(i * p + h);
            check(tg[i], {31'd0, txd}, {31'd0, bits[i]});
        end
        step_to(nf * p - 1);
        check("R2 busy until frame end", {31'd0, tx_ready}, 32'd0);
        step_to(nf * p);
        check("R5 ready at frame end", {31'd0, tx_ready}, 32'd1);
    endtask

    task automatic rx_frame(input logic [7:0] d, input bit flip_par, input bit stop_low,
                            input bit expect_char);
        int         p = int'(baud_div) + 1;
        int         n = nbits(len_code);
        int         c0 = got_cnt;
        logic       pb = par_bit(d, len_code, par_odd) ^ flip_par;
        logic [7:0] md = d & mask(len_code);
        logic       ebk = stop_low && (md == 8'h00) && (!par_en || !pb);
        @(negedge clk);
        rxd = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < n; i++) begin rxd = d[i]; repeat (p) @(negedge clk); end
        if (par_en) begin rxd = pb; repeat (p) @(negedge clk); end
        rxd = !stop_low;
        repeat (p) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * p + 4) @(negedge clk);
        if (!expect_char) begin
            check("R11 rx_en low ignores frame", got_cnt, c0);
        end else begin
            check("R7 one strobe per frame", got_cnt, c0 + 1);
            check("R7 rx_data", {24'd0, got_data}, {24'd0, md});
            check("R8 parity error", {31'd0, got_pe}, {31'd0, par_en && flip_par && !ebk});
            check("R9 break", {31'd0, got_bk}, {31'd0, ebk});
            check("R9 framing error", {31'd0, got_fe}, {31'd0, stop_low && !ebk});
        end
    endtask

    task automatic set_cfg(input logic [15:0] dv, input logic [1:0] lc, input logic pe,
                           input logic po, input logic ts);
        @(negedge clk);
        baud_div = dv; len_code = lc; par_en = pe; par_odd = po; two_stop = ts;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R1 reset tx_ready", {31'd0, tx_ready}, 32'd1);
        check("R1 reset idle line", {31'd0, txd}, 32'd1);
        check("R7 reset no strobe", got_cnt, 0);

        // R3: every length code, with R2 timing
        for (int c = 0; c < 4; c++) begin
            set_cfg(16'd3, 2'(c), 1'b0, 1'b0, 1'b0);
            tx_frame(8'hA5);
        end
        // R4 both senses, R5 two stop bits
        set_cfg(16'd4, 2'd0, 1'b1, 1'b0, 1'b1); tx_frame(8'h37);
        set_cfg(16'd4, 2'd3, 1'b1, 1'b1, 1'b0); tx_frame(8'h37);
        set_cfg(16'd2, 2'd1, 1'b1, 1'b1, 1'b1); tx_frame(8'h00);

        // R6 output disabled
        @(negedge clk) out_en = 1'b0;
        tx_frame(8'h00);
        @(negedge clk) out_en = 1'b1;

        // R11 transmit enable off
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk);
        check("R11 tx_en low keeps tx_ready low", {31'd0, tx_ready}, 32'd0);
        @(negedge clk) tx_en = 1'b1;

        // R10 clear mid-frame, configuration kept
        set_cfg(16'd7, 2'd2, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        tx_data = 8'hFF; tx_valid = 1'b1;
        @(posedge clk);
        #1 tx_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 start bit before clear", {31'd0, txd}, 32'd0);
        sw_clear = 1'b1;
        @(negedge clk) sw_clear = 1'b0;
        check("R10 line idle after clear", {31'd0, txd}, 32'd1);
        check("R10 ready after clear", {31'd0, tx_ready}, 32'd1);
        tx_frame(8'h2C);

        // Receive directed cases
        set_cfg(16'd5, 2'd0, 1'b0, 1'b0, 1'b0);
        rx_frame(8'hC3, 1'b0, 1'b0, 1'b1);
        set_cfg(16'd5, 2'd1, 1'b1, 1'b0, 1'b0);
        rx_frame(8'hF6, 1'b0, 1'b0, 1'b1);
        rx_frame(8'h15, 1'b1, 1'b0, 1'b1);   // R8 parity error
        rx_frame(8'h15, 1'b0, 1'b1, 1'b1);   // R9 framing error
        rx_frame(8'h00, 1'b0, 1'b1, 1'b1);   // R9 break with even parity
        set_cfg(16'd3, 2'd0, 1'b0, 1'b0, 1'b0);
        rx_frame(8'h00, 1'b0, 1'b1, 1'b1);   // R9 break, no parity
        rx_frame(8'h80, 1'b0, 1'b1, 1'b1);   // R9 framing, top bit set
        @(negedge clk) rx_en = 1'b0;
        rx_frame(8'h5A, 1'b0, 1'b0, 1'b0);   // R11
        @(negedge clk) rx_en = 1'b1;
        rx_frame(8'h5A, 1'b0, 1'b0, 1'b1);

        // Random frames in both directions
        for (int k = 0; k < 24; k++) begin
            logic [7:0] d = 8'($urandom);
            bit fl = ($urandom % 4) == 0;
            bit sl = ($urandom % 4) == 0;
            set_cfg(16'(1 + $urandom % 9), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            if (($urandom % 3) == 0) d = 8'h00;
            tx_frame(d);
            rx_frame(d, fl, sl, 1'b1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule